// File: doc/BRIEF.md
# CAN Bit-Timing Quantum Generator

This block derives the time quantum of a CAN node from its peripheral clock and walks each bit through its four segments. A prescaler counts clock cycles and pulses a quantum tick once every (extension value + 1) cycles. A segment sequencer counts those ticks and steps through four segments in a fixed order: sync, propagation, phase 1 and phase 2. It reports the segment in progress, pulses a strobe at the sample point and pulses another strobe at the end of each bit.

The prescaler extension and the three programmable segment lengths come in on plain input buses. They are copied into an internal working set only on the clock edge that ends a bit, so a bit that has already started always finishes with the settings it began with. After reset the working set holds an effective prescaler of 1 and segment lengths of one quantum each. The first bit after reset is therefore four clock cycles long, whatever the inputs are. At a 24 MHz clock with a prescaler of 1, a bit of 24 quanta gives a 1 Mbit/s rate.

Top module: `bit_quanta_gen`

## Requirements
- R1: While reset is held, segCode reads 0 and neither samplePulse nor bitEndPulse is asserted.
- R2: The first bit after reset uses an effective prescaler of 1 and lengths of one quantum for every segment, so it lasts 4 clock cycles regardless of the configuration inputs.
- R3: A quantum lasts prescExt+1 clock cycles. quantumTick is high during the last cycle of each quantum and low in all other cycles.
- R4: Each bit runs its segments in the order sync, propagation, phase 1, phase 2. segCode encodes them as 0, 1, 2 and 3. The sync segment always lasts exactly one quantum.
- R5: The propagation, phase 1 and phase 2 segments last propLen, ph1Len and ph2Len quanta. A programmed length of 0 is treated as 1.
- R6: samplePulse is high for exactly one clock per bit: the last cycle of the last quantum of phase 1.
- R7: bitEndPulse is high for exactly one clock per bit: the last cycle of the last quantum of phase 2. A bit therefore lasts (prescExt+1)·(1+propLen+ph1Len+ph2Len) cycles.
- R8: Configuration inputs are captured only on the edge that ends a bit, while bitEndPulse is high. Changing them during a bit has no effect on that bit.
- R9: With prescExt=0, propLen=7, ph1Len=8 and ph2Len=8, a bit lasts 24 cycles and its sample point falls at cycle 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescExt | input | PRESC_W | Prescaler extension; effective prescaler is this value plus 1 |
| propLen | input | SEG_W | Propagation segment length in quanta |
| ph1Len | input | SEG_W | Phase 1 segment length in quanta |
| ph2Len | input | SEG_W | Phase 2 segment length in quanta |
| quantumTick | output | 1 | High during the last clock of each quantum |
| segCode | output | 2 | Current segment: 0 sync, 1 propagation, 2 phase 1, 3 phase 2 |
| samplePulse | output | 1 | Sample-point strobe |
| bitEndPulse | output | 1 | Bit-boundary strobe |

## Verification
All outputs are decoded from registered counters, so each one is due in the very cycle that its position in the bit implies. Cycle k of a bit (counting from 1) falls in quantum ceil(k/(prescExt+1)), and the tick, segment, sample and end values all follow from that number. The bench samples 1 ns after each rising edge and compares every cycle of every bit against those formulas. New settings are applied part-way through each bit at a random cycle. They are expected to show up only in the bit after the next boundary edge, so the bit in progress is still checked against the old settings.

// File: rtl/bqg_pkg.sv
package bqg_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  typedef struct packed {
    logic loadCfg;   // bit ends this cycle: capture new settings
    logic samplePt;  // sample point this cycle
  } ctrl_strobe_t;
endpackage

// File: rtl/bqg_datapath.sv
module bqg_datapath #(
  parameter int PRESC_W = 10,
  parameter int SEG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] prescExt,
  input  logic [SEG_W-1:0]   propLen,
  input  logic [SEG_W-1:0]   ph1Len,
  input  logic [SEG_W-1:0]   ph2Len,
  input  logic               loadCfg,
  output logic               quantumTick,
  output logic [SEG_W-1:0]   actProp,
  output logic [SEG_W-1:0]   actPh1,
  output logic [SEG_W-1:0]   actPh2
);
  localparam logic [SEG_W-1:0]   LEN_ONE  = SEG_W'(1);
  localparam logic [PRESC_W-1:0] PRE_ZERO = '0;

  logic [PRESC_W-1:0] actPresc;
  logic [PRESC_W-1:0] preCnt;

  function automatic logic [SEG_W-1:0] atLeastOne(input logic [SEG_W-1:0] v);
    return (v == '0) ? LEN_ONE : v;
  endfunction

  assign quantumTick = (preCnt == actPresc);

  // Working configuration, replaced only at a bit boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actPresc <= PRE_ZERO;
      actProp  <= LEN_ONE;
      actPh1   <= LEN_ONE;
      actPh2   <= LEN_ONE;
    end else if (loadCfg) begin
      actPresc <= prescExt;
      actProp  <= atLeastOne(propLen);
      actPh1   <= atLeastOne(ph1Len);
      actPh2   <= atLeastOne(ph2Len);
    end
  end

  // Clock-cycle counter inside one quantum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           preCnt <= PRE_ZERO;
    else if (quantumTick) preCnt <= PRE_ZERO;
    else                  preCnt <= preCnt + 1'b1;
  end
endmodule

// File: rtl/bqg_control.sv
module bqg_control
  import bqg_pkg::*;
#(
  parameter int SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quantumTick,
  input  logic [SEG_W-1:0] actProp,
  input  logic [SEG_W-1:0] actPh1,
  input  logic [SEG_W-1:0] actPh2,
  output seg_e             seg,
  output ctrl_strobe_t     strobes
);
  localparam logic [SEG_W-1:0] Q_ZERO = '0;

  logic [SEG_W-1:0] qCnt;
  logic [SEG_W-1:0] curLen;
  logic             lastQ;

  always_comb begin
    case (seg)
      SEG_PROP: curLen = actProp;
      SEG_PH1:  curLen = actPh1;
      SEG_PH2:  curLen = actPh2;
      default:  curLen = SEG_W'(1);
    endcase
  end

  assign lastQ            = (qCnt == curLen - 1'b1);
  assign strobes.samplePt = quantumTick && lastQ && (seg == SEG_PH1);
  assign strobes.loadCfg  = quantumTick && lastQ && (seg == SEG_PH2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg  <= SEG_SYNC;
      qCnt <= Q_ZERO;
    end else if (quantumTick) begin
      if (lastQ) begin
        seg  <= seg_e'(seg + 2'd1);
        qCnt <= Q_ZERO;
      end else begin
        qCnt <= qCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bit_quanta_gen.sv
module bit_quanta_gen
  import bqg_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int SEG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] prescExt,
  input  logic [SEG_W-1:0]   propLen,
  input  logic [SEG_W-1:0]   ph1Len,
  input  logic [SEG_W-1:0]   ph2Len,
  output logic               quantumTick,
  output logic [1:0]         segCode,
  output logic               samplePulse,
  output logic               bitEndPulse
);
  logic [SEG_W-1:0] actProp, actPh1, actPh2;
  seg_e             seg;
  ctrl_strobe_t     strobes;

  bqg_datapath #(.PRESC_W(PRESC_W), .SEG_W(SEG_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .prescExt    (prescExt),
    .propLen     (propLen),
    .ph1Len      (ph1Len),
    .ph2Len      (ph2Len),
    .loadCfg     (strobes.loadCfg),
    .quantumTick (quantumTick),
    .actProp     (actProp),
    .actPh1      (actPh1),
    .actPh2      (actPh2)
  );

  bqg_control #(.SEG_W(SEG_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .quantumTick (quantumTick),
    .actProp     (actProp),
    .actPh1      (actPh1),
    .actPh2      (actPh2),
    .seg         (seg),
    .strobes     (strobes)
  );

  assign segCode     = seg;
  assign samplePulse = strobes.samplePt;
  assign bitEndPulse = strobes.loadCfg;
endmodule

// File: rtl/bit_quanta_gen_checker.sv
module bit_quanta_gen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       quantumTick,
  input logic [1:0] segCode,
  input logic       samplePulse,
  input logic       bitEndPulse
);
  // R3: the segment can only move on a quantum tick
  assert_seg_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !quantumTick |=> $stable(segCode));

  // R4: a new bit always starts in the sync segment
  assert_sync_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bitEndPulse |=> (segCode == 2'd0));

  // R6: phase 2 follows the sample point
  assert_ph2_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    samplePulse |=> (segCode == 2'd3));

  // R6: sample strobe only on a tick, inside phase 1
  assert_sample_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    samplePulse |-> (quantumTick && segCode == 2'd2));

  // R7: boundary strobe only on a tick, inside phase 2, never with the sample strobe
  assert_end_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bitEndPulse |-> (quantumTick && segCode == 2'd3 && !samplePulse));
endmodule

bind bit_quanta_gen bit_quanta_gen_checker u_bqg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .quantumTick (quantumTick),
  .segCode     (segCode),
  .samplePulse (samplePulse),
  .bitEndPulse (bitEndPulse)
);

// File: tb/bit_quanta_gen_bench.sv
`timescale 1ns/1ps
module bit_quanta_gen_bench;
  localparam int PW = 10;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] prescExt;
  logic [SW-1:0] propLen, ph1Len, ph2Len;
  logic          quantumTick, samplePulse, bitEndPulse;
  logic [1:0]    segCode;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int curP, curPr, curP1, curP2;

  bit_quanta_gen #(.PRESC_W(PW), .SEG_W(SW)) u_bit_quanta_gen (
    .clk(clk), .rst_n(rst_n), .prescExt(prescExt), .propLen(propLen),
    .ph1Len(ph1Len), .ph2Len(ph2Len), .quantumTick(quantumTick),
    .segCode(segCode), .samplePulse(samplePulse), .bitEndPulse(bitEndPulse)
  );

  always #4 clk = ~clk;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int expSeg(input int q, input int pr, input int p1);
    if (q == 1) return 0;
    if (q <= 1 + pr) return 1;
    if (q <= 1 + pr + p1) return 2;
    return 3;
  endfunction

  task automatic check(input int got, input int exp, input string tag);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic driveCfg(input int p, input int pr, input int p1, input int p2);
    prescExt = PW'(p);
    propLen  = SW'(pr);
    ph1Len   = SW'(p1);
    ph2Len   = SW'(p2);
  endtask

  // Run one bit with the current working config; new raw config goes in mid-bit (R8)
  task automatic runBit(input int nP, input int nPr, input int nP1, input int nP2,
                        input string ctx);
    int q, len, chgAt, quanta;
    q      = curP + 1;
    len    = q * (1 + curPr + curP1 + curP2);
    chgAt  = 1 + int'($urandom % 32'(len - 1));
    quanta = 0;
    for (int k = 1; k <= len; k++) begin
      quanta = (k - 1) / q + 1;
      check(int'(quantumTick), int'((k % q) == 0), {ctx, " R3 tick"});
      check(int'(segCode), expSeg(quanta, curPr, curP1), {ctx, " R4/R5 segment"});
      check(int'(samplePulse),
            int'((k % q) == 0 && quanta == 1 + curPr + curP1), {ctx, " R6 sample"});
      check(int'(bitEndPulse), int'(k == len), {ctx, " R7 boundary (R8 old cfg kept)"});
      @(posedge clk); #1;
      if (k == chgAt) driveCfg(nP, nPr, nP1, nP2);
    end
    curP = nP; curPr = eff(nPr); curP1 = eff(nP1); curP2 = eff(nP2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    driveCfg(3, 5, 5, 5);
    repeat (3) @(posedge clk);
    #1;
    check(int'(segCode), 0, "R1 reset segment");
    check(int'(samplePulse), 0, "R1 reset sample");
    check(int'(bitEndPulse), 0, "R1 reset boundary");
    rst_n = 1'b1;
    curP = 0; curPr = 1; curP1 = 1; curP2 = 1;
    // R2: defaults apply for the first bit, the 24-quanta example comes next (R9)
    runBit(0, 7, 8, 8, "R2 first bit");
    runBit(2, 0, 0, 0, "R9 24-quanta bit");
    runBit(63, 15, 15, 15, "R5 zero lengths clamp");
    runBit(1, 3, 4, 2, "R3 large prescaler");
    for (int i = 0; i < 40; i++) begin
      runBit(int'($urandom % 8), int'($urandom % 16), int'($urandom % 16),
             int'($urandom % 16), "R8 random");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule